// File: doc/BRIEF.md
# Horizontal Drive Clock-Source Supervisor

This block drives the horizontal drive output `hout` from one of two timing sources. One is the horizontal pulse from a deflection PLL, whose duty cycle is set elsewhere. The other is a local standby waveform built from the 5 MHz clock. The 5 MHz clock is first divided to a 1 MHz standby tick, and a counter of those ticks then sets the level every half line, which gives a 50% duty cycle. Every input is asynchronous to the reference oscillator `clk` and is synchronized into its domain.

After reset `hout` stays low until a clock-present detector has seen the 5 MHz clock toggle at the right rate for a set number of consecutive measurement windows. The output then runs from the standby source. The host moves it onto the PLL pulse by setting `pll_enable`. It falls back to standby when that bit is cleared, or when a power-down condition is active. A power-down condition comes from a supply-low flag that lasts longer than a short filter time. It is held for a long stretch after the supply recovers.

A change of source takes effect only at an edge of `hout`. The first phase after the change is never shorter than a normal phase of the source it comes from or goes to, so the output has no glitch and no runt pulse.

Top module: `hdrv_hout_supervisor`

## Requirements
- R1: While `rst_n` is low, `hout` is low.
- R2: `hout` stays low while the 5 MHz clock is absent. It also stays low until `GOOD_WIN` consecutive windows of `WIN_CYC` reference cycles have each counted between `EDGE_MIN` and `EDGE_MAX` rising edges of `clk5_in`. If the clock is judged invalid, `hout` goes low on the next cycle.
- R3: In standby, `hout` toggles every `DIV*HALF_TICKS` rising edges of `clk5_in`. The high phase and the low phase are equal (50% duty). The first phase after release is low.
- R4: `hout` follows `pll_hdrive` and keeps its high and low widths only while `pll_enable` is 1, the clock is valid and no power-down is active. Without all three, `hout` never enters the PLL-following state.
- R5: When `pll_enable` is cleared, `hout` returns to the 50% standby waveform of R3.
- R6: A `supply_low` pulse that lasts no more than `GLITCH_CYC` reference cycles after synchronization is ignored, and `hout` keeps following the PLL. A longer pulse raises power-down, which moves `hout` to the standby waveform exactly as clearing `pll_enable` would.
- R7: Power-down stays active for `STRETCH_CYC` reference cycles after `supply_low` returns low, and it cannot end while `supply_low` is still high.
- R8: `hout` changes only on a standby half-period event, on a synchronized `pll_hdrive` edge, or when the clock is lost. Once `hout` has been released, no phase is shorter than the shortest phase of the active sources. The first standby phase after a switch lasts a full standby half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk5_in | input | 1 | 5 MHz clock, asynchronous |
| pll_hdrive | input | 1 | Horizontal pulse from the deflection PLL, asynchronous |
| supply_low | input | 1 | Digital supply below threshold, asynchronous |
| pll_enable | input | 1 | Host request to couple `hout` to the PLL |
| hout | output | 1 | Horizontal drive output |

## Verification
On every cycle, the bound checker checks four things. `hout` moves only on a legal source event. The output drops as soon as the clock is invalid. The PLL-following state is entered only when it was requested. Power-down starts only while the supply is low and never ends while the supply is still low. The directed scenarios are needed for everything that spans many cycles: the exact standby half-period width, the preserved PLL duty, the glitch filter rejecting a short pulse, the full length of the stretch before PLL coupling returns, and the minimum phase width across all switches.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_STBY   = 2'd1,
    SRC_TO_PLL = 2'd2,
    SRC_PLL    = 2'd3
  } src_state_e;

  // a window passes when its edge count lies inside the accepted band
  function automatic logic window_ok(input int unsigned edges,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (edges >= lo) && (edges <= hi);
  endfunction

  // standby half period measured in 5 MHz rising edges
  function automatic int unsigned stby_half_edges(input int unsigned div,
                                                  input int unsigned half_ticks);
    return div * half_ticks;
  endfunction

endpackage

// File: rtl/hdrv_sync.sv
module hdrv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hdrv_clk_detect.sv
module hdrv_clk_detect
  import hdrv_pkg::*;
#(
  parameter int WIN_CYC  = 500,
  parameter int EDGE_MIN = 8,
  parameter int EDGE_MAX = 12,
  parameter int GOOD_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_s,
  output logic clk5_rise,
  output logic clk_valid
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(EDGE_MAX + 2);
  localparam int GW = $clog2(GOOD_WIN + 1);

  logic          clk5_d;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [GW-1:0] good_cnt;
  logic          win_end, win_good;

  assign clk5_rise = clk5_s & ~clk5_d;
  assign win_end   = (win_cnt == WW'(WIN_CYC - 1));
  assign win_good  = window_ok(int'(edge_cnt), EDGE_MIN, EDGE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk5_d    <= 1'b0;
      win_cnt   <= '0;
      edge_cnt  <= '0;
      good_cnt  <= '0;
      clk_valid <= 1'b0;
    end else begin
      clk5_d <= clk5_s;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= EW'(clk5_rise);
        if (win_good) begin
          if (good_cnt != GW'(GOOD_WIN)) good_cnt <= good_cnt + 1'b1;
          clk_valid <= (good_cnt >= GW'(GOOD_WIN - 1));
        end else begin
          good_cnt  <= '0;
          clk_valid <= 1'b0;
        end
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (clk5_rise && edge_cnt != EW'(EDGE_MAX + 1)) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdrv_pd_filter.sv
module hdrv_pd_filter #(
  parameter int GLITCH_CYC  = 13,
  parameter int STRETCH_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_s,
  output logic pd,
  output logic pd_trip
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC);

  logic [GW-1:0] low_cnt;
  logic [SW-1:0] hold_cnt;
  logic          hold_done;

  assign pd_trip   = low_s && (low_cnt == GW'(GLITCH_CYC));
  assign hold_done = (hold_cnt == SW'(STRETCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      hold_cnt <= '0;
      pd       <= 1'b0;
    end else begin
      if (!low_s) low_cnt <= '0;
      else if (low_cnt != GW'(GLITCH_CYC)) low_cnt <= low_cnt + 1'b1;

      if (pd_trip || (pd && low_s)) begin
        pd       <= 1'b1;
        hold_cnt <= '0;
      end else if (pd) begin
        hold_cnt <= hold_cnt + 1'b1;
        if (hold_done) pd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdrv_stby_gen.sv
module hdrv_stby_gen #(
  parameter int DIV        = 5,
  parameter int HALF_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_rise,
  input  logic restart,
  output logic stby_tog
);
  localparam int DW = $clog2(DIV);
  localparam int HW = $clog2(HALF_TICKS);

  logic [DW-1:0] div_cnt;
  logic [HW-1:0] half_cnt;
  logic          tick;

  assign tick     = clk5_rise && (div_cnt == DW'(DIV - 1));
  assign stby_tog = tick && (half_cnt == HW'(HALF_TICKS - 1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      half_cnt <= '0;
    end else if (restart) begin
      div_cnt  <= '0;
      half_cnt <= '0;
    end else if (clk5_rise) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) half_cnt <= (half_cnt == HW'(HALF_TICKS - 1)) ? '0 : half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdrv_hout_supervisor.sv
module hdrv_hout_supervisor
  import hdrv_pkg::*;
#(
  parameter int WIN_CYC     = 500,
  parameter int EDGE_MIN    = 8,
  parameter int EDGE_MAX    = 12,
  parameter int GOOD_WIN    = 4,
  parameter int DIV         = 5,
  parameter int HALF_TICKS  = 32,
  parameter int GLITCH_CYC  = 13,
  parameter int STRETCH_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk5_in,
  input  logic pll_hdrive,
  input  logic supply_low,
  input  logic pll_enable,
  output logic hout
);
  logic [2:0] raw_in, sync_out;
  logic       clk5_s, pll_s, low_s, pll_d;
  logic       clk5_rise, clk_valid, pd, pd_trip;
  logic       stby_tog, stby_restart, pll_edge, want_pll, hout_evt, sel_pll;
  logic       hout_q, hout_nx, min_done, min_nx;
  src_state_e state, state_nx;

  assign raw_in = {supply_low, pll_hdrive, clk5_in};

  hdrv_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign {low_s, pll_s, clk5_s} = sync_out;

  hdrv_clk_detect #(
    .WIN_CYC(WIN_CYC), .EDGE_MIN(EDGE_MIN), .EDGE_MAX(EDGE_MAX), .GOOD_WIN(GOOD_WIN)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .clk5_s(clk5_s), .clk5_rise(clk5_rise), .clk_valid(clk_valid)
  );

  hdrv_pd_filter #(.GLITCH_CYC(GLITCH_CYC), .STRETCH_CYC(STRETCH_CYC)) u_pd (
    .clk(clk), .rst_n(rst_n), .low_s(low_s), .pd(pd), .pd_trip(pd_trip)
  );

  hdrv_stby_gen #(.DIV(DIV), .HALF_TICKS(HALF_TICKS)) u_stby (
    .clk(clk), .rst_n(rst_n), .clk5_rise(clk5_rise), .restart(stby_restart), .stby_tog(stby_tog)
  );

  assign pll_edge = pll_s ^ pll_d;
  assign want_pll = clk_valid && pll_enable && !pd;
  assign hout_evt = stby_tog || pll_edge || !clk_valid;
  assign sel_pll  = (state == SRC_PLL);
  assign hout     = hout_q;

  always_comb begin
    state_nx     = state;
    hout_nx      = hout_q;
    min_nx       = min_done;
    stby_restart = 1'b0;
    unique case (state)
      SRC_OFF: begin
        hout_nx = 1'b0;
        if (clk_valid) begin
          state_nx     = SRC_STBY;
          stby_restart = 1'b1;
        end
      end
      SRC_STBY: begin
        if (stby_tog) begin
          hout_nx = ~hout_q;
          if (want_pll) begin
            state_nx = SRC_TO_PLL;
            min_nx   = 1'b0;
          end
        end
      end
      SRC_TO_PLL: begin
        if (!want_pll) begin
          state_nx = SRC_STBY;
          if (stby_tog) hout_nx = ~hout_q;
        end else if (min_done && pll_edge && (pll_s != hout_q)) begin
          hout_nx  = pll_s;
          state_nx = SRC_PLL;
        end else if (stby_tog) begin
          min_nx = 1'b1;
        end
      end
      SRC_PLL: begin
        if (pll_edge) begin
          hout_nx = pll_s;
          if (!want_pll) begin
            state_nx     = SRC_STBY;
            stby_restart = 1'b1;
          end
        end
      end
      default: state_nx = SRC_OFF;
    endcase
    if (!clk_valid) begin
      state_nx = SRC_OFF;
      hout_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SRC_OFF;
      hout_q   <= 1'b0;
      min_done <= 1'b0;
      pll_d    <= 1'b0;
    end else begin
      state    <= state_nx;
      hout_q   <= hout_nx;
      min_done <= min_nx;
      pll_d    <= pll_s;
    end
  end
endmodule

// File: rtl/hdrv_sva.sv
module hdrv_sva (
  input logic clk,
  input logic rst_n,
  input logic hout,
  input logic clk_valid,
  input logic hout_evt,
  input logic sel_pll,
  input logic want_pll,
  input logic pd,
  input logic low_s
);
  p_off_when_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_valid |=> !hout);

  p_pll_only_on_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_pll) |-> $past(want_pll));

  p_trip_needs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> $past(low_s));

  p_hold_while_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && low_s) |=> pd);

  p_edge_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hout) |-> $past(hout_evt));
endmodule

bind hdrv_hout_supervisor hdrv_sva u_sva (
  .clk(clk), .rst_n(rst_n), .hout(hout), .clk_valid(clk_valid), .hout_evt(hout_evt),
  .sel_pll(sel_pll), .want_pll(want_pll), .pd(pd), .low_s(low_s)
);

// File: tb/sim_hdrv_hout_supervisor.sv
`timescale 1ns/1ps
module sim_hdrv_hout_supervisor;
  localparam int HALF_W    = 1000;  // 4*5 clk5 edges * 50 ref cycles
  localparam int PLL_HI    = 300;
  localparam int PLL_LO    = 700;
  localparam int STRETCH   = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk5 = 1'b0, pll_h = 1'b0, supply_low = 1'b0, pll_enable = 1'b0;
  logic hout;
  bit   clk5_on = 1'b0;
  int   total = 0, bad = 0;
  bit   mon_on = 1'b0;
  time  last_edge = 0;
  int   min_w = 1 << 30;

  hdrv_hout_supervisor #(.HALF_TICKS(4), .STRETCH_CYC(STRETCH)) u0 (
    .clk(clk), .rst_n(rst_n), .clk5_in(clk5), .pll_hdrive(pll_h),
    .supply_low(supply_low), .pll_enable(pll_enable), .hout(hout)
  );

  always #2 clk = ~clk;                       // 250 MHz
  always begin #100; clk5 = clk5_on ? ~clk5 : 1'b0; end
  initial begin #1; forever begin pll_h = 1'b1; #1200; pll_h = 1'b0; #2800; end end

  always @(hout) if (mon_on) begin
    if (last_edge != 0 && int'(($time - last_edge) / 4) < min_w) min_w = int'(($time - last_edge) / 4);
    last_edge = $time;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas_high(output int w, output time t0);
    @(posedge hout); t0 = $time; @(negedge hout); w = int'(($time - t0) / 4);
  endtask

  task automatic meas_low(output int w);
    time t0;
    @(negedge hout); t0 = $time; @(posedge hout); w = int'(($time - t0) / 4);
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 2) && (a <= e + 2);
  endfunction

  task automatic t_reset;
    wait_cyc(5);
    chk(hout == 1'b0, "R1 reset low", hout, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_startup;
    int w; time t0;
    wait_cyc(5000);
    chk(hout == 1'b0, "R2 no clock", hout, 0);
    clk5_on = 1'b1;
    wait_cyc(1500);
    chk(hout == 1'b0, "R2 qualifying", hout, 0);
    meas_high(w, t0);
    mon_on = 1'b1; last_edge = $time - time'(w * 4);
    chk(near(w, HALF_W), "R3 standby high", w, HALF_W);
    meas_low(w);
    chk(near(w, HALF_W), "R3 standby low", w, HALF_W);
  endtask

  task automatic t_pll_on;
    int w; time t0;
    pll_enable = 1'b1;
    wait_cyc(4500);
    meas_high(w, t0);
    chk(near(w, PLL_HI), "R4 pll high", w, PLL_HI);
    meas_low(w);
    chk(near(w, PLL_LO), "R4 pll low", w, PLL_LO);
  endtask

  task automatic t_glitch;
    int w; time t0;
    @(negedge clk); supply_low = 1'b1;
    wait_cyc(10);
    supply_low = 1'b0;
    wait_cyc(100);
    for (int i = 0; i < 3; i++) begin
      meas_high(w, t0);
      chk(near(w, PLL_HI), "R6 short pulse ignored", w, PLL_HI);
    end
  endtask

  task automatic t_powerdown;
    int w; time t0, t_rel; bit found;
    @(negedge clk); supply_low = 1'b1;
    wait_cyc(2100);
    meas_high(w, t0);
    chk(near(w, HALF_W), "R6 power-down to standby", w, HALF_W);
    @(negedge clk); supply_low = 1'b0; t_rel = $time;
    found = 1'b0;
    for (int i = 0; i < 10 && !found; i++) begin
      meas_high(w, t0);
      if (near(w, PLL_HI)) found = 1'b1;
    end
    chk(found, "R7 pll returns", int'(found), 1);
    chk(t0 >= t_rel + time'(STRETCH * 4), "R7 stretch held",
        int'((t0 - t_rel) / 4), STRETCH);
  endtask

  task automatic t_pll_off;
    int w; time t0;
    @(negedge clk); pll_enable = 1'b0;
    wait_cyc(2100);
    meas_high(w, t0);
    chk(near(w, HALF_W), "R5 back to standby high", w, HALF_W);
    meas_low(w);
    chk(near(w, HALF_W), "R5 back to standby low", w, HALF_W);
  endtask

  initial begin
    #(4 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_pll_on();
    t_glitch();
    t_powerdown();
    t_pll_off();
    chk(min_w >= PLL_HI - 2, "R8 no runt phase", min_w, PLL_HI);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule